// File: doc/BRIEF.md
# Masked Burst-Write Engine for a Two-Bank Graphics Memory

This block is the write datapath of a two-bank synchronous graphics memory model with a 32-bit data bus. On every rising clock edge it takes one decoded command with a bank select and a column address. A write command starts a burst of four data words, one per clock. The first word is taken on the edge that registers the command, and the column advances inside an aligned group of four. Each stored bit is gated twice. A programmable per-bit mask register lets through only the bits whose mask bit is 1. A per-byte lane disable input blocks every bit of its byte when high. Bits that are not enabled keep their old content.

A burst can be cut short on any later cycle. A new write abandons the old burst and starts its own on the same edge. A read, a precharge of the bursting bank, a precharge of all banks, or a mask load ends the burst, and nothing is stored on that edge or after it. A precharge aimed at the other bank leaves the burst running. The mask register is loaded from the data bus by its own command. A combinational array read port exposes any stored word. The storage depth is scaled down by a parameter for simulation.

Top module: `sgm_burst_writer`

## Requirements
- R1: After reset every word of both banks reads zero and the per-bit mask register holds all ones.
- R2: A WRITE command (code 1) stores the word on `dq_in` at the issued bank and column on the same clock edge that registers the command.
- R3: After a WRITE, each of the next three edges whose command is NOP (code 0) stores one further word. Its column keeps the upper bits of the start column, and its two low bits are the start column's low bits plus 1, 2 and 3, modulo 4. No further word is stored after these three.
- R4: A written bit whose mask register bit is 0 keeps its old value. A bit whose mask bit is 1 takes the `dq_in` bit.
- R5: When `dqm[i]` is 1, bits [8i+7:8i] of the addressed word are left unchanged on that write.
- R6: A LOAD_MASK command (code 5) copies `dq_in` into the mask register. It ends any burst in progress, and nothing is stored on that edge or afterwards for that burst.
- R7: A WRITE issued while a burst is running ends the old burst and starts a new one at the new address on the same edge.
- R8: A READ command (code 2) ends a running burst. Nothing is stored on its edge, and data on `dq_in` during later NOP cycles is ignored.
- R9: A PRECHARGE (code 3) naming the bursting bank, or a PRECHARGE_ALL (code 4), ends the burst, and nothing is stored on its edge.
- R10: A PRECHARGE naming the other bank does not interrupt the burst. The word on `dq_in` at that edge is stored as the next burst word. Codes 6 and 7 act as NOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Decoded command code |
| bank | input | 1 | Bank select for WRITE and PRECHARGE |
| col | input | COL_W | Column address for WRITE |
| dq_in | input | DATA_W | Write data, or the mask value for LOAD_MASK |
| dqm | input | DATA_W/8 | Per-byte write disable, 1 = lane blocked |
| rd_bank | input | 1 | Array read port bank select |
| rd_col | input | COL_W | Array read port column |
| rd_data | output | DATA_W | Stored word at rd_bank/rd_col |

## Verification
The bench sweeps full bursts from every start column of both banks. An engine that carried into the upper column bits, or that kept writing past four words, would corrupt neighbouring aligned groups. It interrupts bursts at each of the three possible offsets with a write, a read, a same-bank precharge, a precharge-all and a mask load. A design that stored the interrupting cycle's data, or that resumed after a read, leaves words the reference copy does not have. It also sweeps all sixteen byte-disable patterns and several mask values, and it precharges the idle bank mid-burst. A swapped mask polarity, a lane off by one, or an over-eager interrupt then shows up as whole-array miscompares.

// File: rtl/sgm_pkg.sv
package sgm_pkg;
    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_WRITE     = 3'd1,
        CMD_READ      = 3'd2,
        CMD_PRE       = 3'd3,
        CMD_PRE_ALL   = 3'd4,
        CMD_LOAD_MASK = 3'd5
    } sgm_cmd_e;
endpackage

// File: rtl/sgm_burst_ctrl.sv
// Burst sequencer and per-bit mask register (two-process style).
module sgm_burst_ctrl
    import sgm_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int COL_W     = 4,
    parameter int BANK_W    = 1,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] dq_in,
    output logic              wr_en,
    output logic [BANK_W-1:0] wr_bank,
    output logic [COL_W-1:0]  wr_col,
    output logic [DATA_W-1:0] mask_q
);
    localparam int CNT_W = $clog2(BURST_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN - 1);

    typedef struct packed {
        logic              active;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] mask;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  advance;

    always_comb begin
        s_d     = s_q;
        wr_en   = 1'b0;
        wr_bank = s_q.bank;
        wr_col  = {s_q.col[COL_W-1:CNT_W], s_q.col[CNT_W-1:0] + s_q.cnt};
        advance = 1'b0;
        if (cmd == CMD_WRITE) begin
            wr_en     = 1'b1;
            wr_bank   = bank;
            wr_col    = col;
            s_d.active = (BURST_LEN > 1);
            s_d.bank  = bank;
            s_d.col   = col;
            s_d.cnt   = CNT_W'(1);
        end else if (cmd == CMD_LOAD_MASK) begin
            s_d.mask   = dq_in;
            s_d.active = 1'b0;
        end else if (cmd == CMD_READ || cmd == CMD_PRE_ALL) begin
            s_d.active = 1'b0;
        end else if (cmd == CMD_PRE && bank == s_q.bank) begin
            s_d.active = 1'b0;
        end else begin
            advance = s_q.active;
        end
        if (advance) begin
            wr_en = 1'b1;
            if (s_q.cnt == LAST) begin
                s_d.active = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.mask   <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign mask_q = s_q.mask;
endmodule

// File: rtl/sgm_mask_merge.sv
// Combines the per-bit mask with per-byte lane disables and merges data.
module sgm_mask_merge #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   old_word,
    input  logic [DATA_W-1:0]   new_word,
    input  logic [DATA_W-1:0]   bit_mask,
    input  logic [DATA_W/8-1:0] lane_off,
    output logic [DATA_W-1:0]   merged
);
    localparam int LANES = DATA_W / 8;
    logic [DATA_W-1:0] en;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign en[8*i +: 8] = bit_mask[8*i +: 8] & {8{~lane_off[i]}};
    end

    assign merged = (old_word & ~en) | (new_word & en);
endmodule

// File: rtl/sgm_bank_array.sv
// Banked word storage with a merge-read port and an external read port.
module sgm_bank_array #(
    parameter int DATA_W = 32,
    parameter int BANKS  = 2,
    parameter int BANK_W = 1,
    parameter int COL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] old_data,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << COL_W;

    logic [DATA_W-1:0] old_w [BANKS];
    logic [DATA_W-1:0] rd_w  [BANKS];

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
            end else if (wr_en && wr_bank == BANK_W'(g)) begin
                mem[wr_col] <= wr_data;
            end
        end
        assign old_w[g] = mem[wr_col];
        assign rd_w[g]  = mem[rd_col];
    end

    assign old_data = old_w[wr_bank];
    assign rd_data  = rd_w[rd_bank];
endmodule

// File: rtl/sgm_burst_writer.sv
// Top: masked burst-write engine for a two-bank graphics memory model.
module sgm_burst_writer #(
    parameter int DATA_W    = 32,
    parameter int BANKS     = 2,
    parameter int COL_W     = 4,
    parameter int BURST_LEN = 4,
    localparam int BANK_W   = $clog2(BANKS),
    localparam int LANES    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] dq_in,
    input  logic [LANES-1:0]  dqm,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data
);
    logic              wr_en;
    logic [BANK_W-1:0] wr_bank;
    logic [COL_W-1:0]  wr_col;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] old_data;
    logic [DATA_W-1:0] merged;

    sgm_burst_ctrl #(
        .DATA_W(DATA_W), .COL_W(COL_W), .BANK_W(BANK_W), .BURST_LEN(BURST_LEN)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .col(col),
        .dq_in(dq_in), .wr_en(wr_en), .wr_bank(wr_bank), .wr_col(wr_col),
        .mask_q(mask_q)
    );

    sgm_mask_merge #(.DATA_W(DATA_W)) u_merge (
        .old_word(old_data), .new_word(dq_in), .bit_mask(mask_q),
        .lane_off(dqm), .merged(merged)
    );

    sgm_bank_array #(
        .DATA_W(DATA_W), .BANKS(BANKS), .BANK_W(BANK_W), .COL_W(COL_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_col(wr_col), .wr_data(merged), .old_data(old_data),
        .rd_bank(rd_bank), .rd_col(rd_col), .rd_data(rd_data)
    );
endmodule

// File: rtl/sgm_burst_writer_chk.sv
// Property checker, bound into the top module.
module sgm_burst_writer_chk
    import sgm_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int COL_W     = 4,
    parameter int BANK_W    = 1,
    parameter int BURST_LEN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cmd,
    input logic [BANK_W-1:0] bank,
    input logic [COL_W-1:0]  col,
    input logic [DATA_W-1:0] dq_in,
    input logic              wr_en,
    input logic [BANK_W-1:0] wr_bank,
    input logic [COL_W-1:0]  wr_col,
    input logic [DATA_W-1:0] mask_q
);
    localparam int CNT_W = $clog2(BURST_LEN);
    logic [7:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else if (cmd == CMD_WRITE || !wr_en) run_q <= '0;
        else run_q <= run_q + 8'd1;
    end

    assert_write_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_WRITE |-> wr_en && wr_col == col && wr_bank == bank);

    assert_col_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && cmd != CMD_WRITE |-> $past(wr_en)
            && wr_col[CNT_W-1:0] == $past(wr_col[CNT_W-1:0]) + CNT_W'(1)
            && wr_col[COL_W-1:CNT_W] == $past(wr_col[COL_W-1:CNT_W])
            && wr_bank == $past(wr_bank));

    assert_burst_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && cmd != CMD_WRITE |-> run_q < 8'(BURST_LEN - 1));

    assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_LOAD_MASK |=> mask_q == $past(dq_in));

    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != CMD_LOAD_MASK |=> $stable(mask_q));

    assert_read_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ) ##1 (cmd != CMD_WRITE) |-> !wr_en);

    assert_pre_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_PRE_ALL || cmd == CMD_READ || cmd == CMD_LOAD_MASK |-> !wr_en);
endmodule

bind sgm_burst_writer sgm_burst_writer_chk #(
    .DATA_W(DATA_W), .COL_W(COL_W), .BANK_W(BANK_W), .BURST_LEN(BURST_LEN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .col(col), .dq_in(dq_in),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_col(wr_col), .mask_q(mask_q)
);

// File: tb/tb_sgm_burst_writer.sv
module tb_sgm_burst_writer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [0:0]  bank = '0;
    logic [3:0]  col = '0;
    logic [31:0] dq_in = '0;
    logic [3:0]  dqm = '0;
    logic [0:0]  rd_bank = '0;
    logic [3:0]  rd_col = '0;
    logic [31:0] rd_data;

    int vectors = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] ref_mem [2][16];
    logic [31:0] ref_mask;
    bit          b_act;
    logic [0:0]  b_bank;
    logic [3:0]  b_col;
    int          b_cnt;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    sgm_burst_writer dut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .col(col),
        .dq_in(dq_in), .dqm(dqm), .rd_bank(rd_bank), .rd_col(rd_col),
        .rd_data(rd_data)
    );

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic ref_store(input logic [0:0] b, input logic [3:0] c,
                             input logic [31:0] d, input logic [3:0] m);
        logic [31:0] en;
        for (int i = 0; i < 4; i++) en[8*i +: 8] = ref_mask[8*i +: 8] & {8{~m[i]}};
        ref_mem[b][c] = (ref_mem[b][c] & ~en) | (d & en);
    endtask

    // Drive one command at the falling edge; update the reference per R2..R10.
    task automatic step(input logic [2:0] c, input logic [0:0] b, input logic [3:0] a,
                        input logic [31:0] d, input logic [3:0] m);
        @(negedge clk);
        cmd = c; bank = b; col = a; dq_in = d; dqm = m;
        if (c == 3'd1) begin
            ref_store(b, a, d, m);
            b_act = 1; b_bank = b; b_col = a; b_cnt = 1;
        end else if (c == 3'd5) begin
            ref_mask = d; b_act = 0;
        end else if (c == 3'd2 || c == 3'd4 || (c == 3'd3 && b == b_bank)) begin
            b_act = 0;
        end else if (b_act) begin
            ref_store(b_bank, {b_col[3:2], b_col[1:0] + 2'(b_cnt)}, d, m);
            if (b_cnt == 3) b_act = 0;
            else b_cnt++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(3'd0, '0, '0, next_rand(), 4'h0);
    endtask

    task automatic check_all(input string tag);
        idle(4);
        @(negedge clk);
        cmd = 3'd0;
        for (int b = 0; b < 2; b++) begin
            for (int c = 0; c < 16; c++) begin
                rd_bank = 1'(b); rd_col = 4'(c);
                #1;
                vectors++;
                if (rd_data !== ref_mem[b][c]) begin
                    errors++;
                    $display("FAIL %s bank %0d col %0d: got %h expected %h",
                             tag, b, c, rd_data, ref_mem[b][c]);
                end
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int c = 0; c < 16; c++) ref_mem[b][c] = '0;
        ref_mask = '1; b_act = 0; b_bank = '0; b_col = '0; b_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset contents, and the all-ones mask shows through a full write.
        check_all("R1 reset contents");
        step(3'd1, 1'b0, 4'd0, 32'hFFFF_FFFF, 4'h0);
        step(3'd2, 1'b0, 4'd0, 32'h0, 4'h0);
        check_all("R1 mask reset all ones");

        // R2/R3: full bursts from every start column of both banks.
        for (int b = 0; b < 2; b++) begin
            for (int s = 0; s < 16; s++) begin
                step(3'd1, 1'(b), 4'(s), next_rand(), 4'h0);
                idle(5);
                check_all("R2 R3 full burst wrap");
            end
        end

        // R5: every byte-lane disable pattern on a burst.
        for (int p = 0; p < 16; p++) begin
            step(3'd1, 1'(p & 1), 4'(p), next_rand(), 4'(p));
            step(3'd0, '0, '0, next_rand(), 4'(15 - p));
            step(3'd0, '0, '0, next_rand(), 4'(p));
            step(3'd0, '0, '0, next_rand(), 4'h0);
            check_all("R5 lane disable");
        end

        // R4: per-bit mask values.
        for (int k = 0; k < 4; k++) begin
            step(3'd5, '0, '0, next_rand(), 4'h0);
            step(3'd1, 1'(k), 4'(4 * k + 1), next_rand(), 4'h0);
            idle(3);
            check_all("R4 per-bit mask");
        end
        step(3'd5, '0, '0, 32'h0000_0000, 4'h0);
        step(3'd1, 1'b1, 4'd6, next_rand(), 4'h0);
        idle(3);
        check_all("R4 zero mask blocks all");
        step(3'd5, '0, '0, 32'hFFFF_FFFF, 4'h0);

        // Interrupts at each offset within the burst.
        for (int k = 1; k < 4; k++) begin
            step(3'd1, 1'b0, 4'(k + 4), next_rand(), 4'h0);
            idle(k - 1);
            step(3'd1, 1'b1, 4'(k + 8), next_rand(), 4'h0);
            idle(3);
            check_all("R7 write interrupts write");

            step(3'd1, 1'b1, 4'(k), next_rand(), 4'h0);
            idle(k - 1);
            step(3'd2, 1'b1, 4'(k), next_rand(), 4'h0);
            idle(3);
            check_all("R8 read interrupts write");

            step(3'd1, 1'b0, 4'(k + 12), next_rand(), 4'h0);
            idle(k - 1);
            step(3'd3, 1'b0, '0, next_rand(), 4'h0);
            idle(3);
            check_all("R9 same-bank precharge");

            step(3'd1, 1'b1, 4'(15 - k), next_rand(), 4'h0);
            idle(k - 1);
            step(3'd4, 1'b0, '0, next_rand(), 4'h0);
            idle(3);
            check_all("R9 precharge all");

            step(3'd1, 1'b0, 4'(k), next_rand(), 4'h0);
            idle(k - 1);
            step(3'd3, 1'b1, '0, next_rand(), 4'h0);
            idle(3);
            check_all("R10 other-bank precharge");

            step(3'd1, 1'b1, 4'(k + 2), next_rand(), 4'h0);
            idle(k - 1);
            step(3'd5, '0, '0, 32'hF0F0_0FF0 ^ 32'(k), 4'h0);
            idle(3);
            check_all("R6 mask load interrupts");
            step(3'd5, '0, '0, 32'hFFFF_FFFF, 4'h0);
        end

        // R10: reserved codes 6 and 7 continue a burst like NOP.
        step(3'd1, 1'b0, 4'd9, next_rand(), 4'h0);
        step(3'd6, 1'b1, 4'd0, next_rand(), 4'h0);
        step(3'd7, 1'b0, 4'd0, next_rand(), 4'h0);
        step(3'd0, 1'b0, 4'd0, next_rand(), 4'h0);
        check_all("R10 reserved codes as NOP");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule